// File: doc/BRIEF.md
# Time-Multiplexed Timer Bus Sequencer

This block lets up to four timers share one time bus. It gives each timer a slot in a fixed, repeating rotation. During its slot, the block drives that timer's value onto the bus, with a 2-bit tag that names the timer, and raises that timer's slot enable. The timer may advance only when its slot enable is high. A strobe input marks each state time, which is two clock cycles, and one slot lasts one state time.

A mode input chooses the rotation:

- **Two-timer mode (mode 0):** the rotation is timer 2 then timer 1. Each of these timers can change once every two state times, so the fastest count rate is the clock divided by four. Timers 3 and 4 get no slots at all.
- **Four-timer mode (mode 1):** the rotation is timer 4, timer 3, timer 2 and timer 1. Each timer can change once every four state times, so the fastest count rate is the clock divided by eight.

Capture and compare resolution is therefore 4 or 8, times the timer's prescaler divisor, clock periods. A new mode is taken up only at the boundary where a new rotation begins.

Top module: `tbus_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the tag reads 1 (the timer 2 slot), every slot enable is low and the bus value is zero. The internal mode is two-timer.
- R2: In two-timer mode, successive strobes move the tag through 1, 0, 1, 0, and so on. Tag value k means timer k+1.
- R3: In four-timer mode, successive strobes move the tag through 3, 2, 1, 0, then back to 3.
- R4: While the active mode is two-timer, the tag never reads 2 or 3, and slot enables 2 and 3 (timers 3 and 4) stay low.
- R5: In the cycle after a strobe is sampled, exactly one slot enable is high: bit k, where k is the new tag. In the cycle after a clock with no strobe, all slot enables are low.
- R6: At each clock, the bus value is loaded from the timer named by the tag in force after that edge. It therefore appears together with its tag, one cycle after the timer input is sampled.
- R7: The mode input is sampled only by a strobe that arrives while the tag is 0. That strobe loads the tag with 3 if the input is 1, or with 1 if it is 0. At any other strobe the mode input has no effect on the tag.
- R8: A clock with no strobe leaves the tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_stb_i | input | 1 | State-time strobe; one pulse starts the next slot |
| mode_i | input | 1 | 0 = two-timer rotation, 1 = four-timer rotation |
| tmr_val_i | input | N_TIMERS*VAL_W | Timer values packed; timer k+1 occupies bits [k*VAL_W +: VAL_W] |
| bus_val_o | output | VAL_W | Time bus value |
| bus_tag_o | output | TAG_W | Index of the timer currently on the bus |
| slot_en_o | output | N_TIMERS | One-cycle advance permission per timer, one-hot |

## Verification
**Directed pattern.** The first pattern holds a steady two-timer rotation with a strobe every other cycle. A gap of several cycles without strobes then shows that the tag holds when no strobe arrives.

**Mode switch.** The mode input is then flipped to 1 partway through a rotation. This separates a design that takes up the new mode at once from one that waits for the rotation boundary. The switch is repeated in the other direction, from four-timer back to two-timer.

**Random pattern.** A long random run varies three things: the strobe spacing, the mode, and the timer values, which are new every cycle. Because the values change each cycle, an off-by-one-cycle selection or a wrong timer index on the bus is caught. Slots that never rotate, and any mode 0 slot that reaches timers 3 or 4, are caught too.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  typedef enum logic {
    MODE_PAIR = 1'b0,
    MODE_QUAD = 1'b1
  } tbus_mode_e;
endpackage

// File: rtl/tbus_slot_seq.sv
// Slot position and the mode in force for the current rotation.
module tbus_slot_seq
  import tbus_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int TAG_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic             mode_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [TAG_W-1:0] tag_nxt_o,
  output tbus_mode_e       mode_o
);
  localparam logic [TAG_W-1:0] TOP_QUAD = TAG_W'(N_TIMERS - 1);
  localparam logic [TAG_W-1:0] TOP_PAIR = TAG_W'(N_TIMERS / 2 - 1);

  logic [TAG_W-1:0] tag_q, tag_d;
  tbus_mode_e       mode_q, mode_d;

  always_comb begin
    tag_d  = tag_q;
    mode_d = mode_q;
    if (stb_i) begin
      if (tag_q == '0) begin
        // a rotation ends here; the next one follows the mode input
        mode_d = tbus_mode_e'(mode_i);
        tag_d  = (mode_d == MODE_QUAD) ? TOP_QUAD : TOP_PAIR;
      end else begin
        tag_d = tag_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= TOP_PAIR;
      mode_q <= MODE_PAIR;
    end else begin
      tag_q  <= tag_d;
      mode_q <= mode_d;
    end
  end

  assign tag_o     = tag_q;
  assign tag_nxt_o = tag_d;
  assign mode_o    = mode_q;
endmodule

// File: rtl/tbus_out_stage.sv
// Registered bus mux and slot-enable decode, aligned with the tag register.
module tbus_out_stage #(
  parameter int N_TIMERS = 4,
  parameter int VAL_W    = 16,
  parameter int TAG_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      stb_i,
  input  logic [TAG_W-1:0]          tag_nxt_i,
  input  logic [N_TIMERS*VAL_W-1:0] tmr_val_i,
  output logic [VAL_W-1:0]          bus_val_o,
  output logic [N_TIMERS-1:0]       slot_en_o
);
  logic [VAL_W-1:0]    vals [N_TIMERS];
  logic [N_TIMERS-1:0] en_d;

  for (genvar k = 0; k < N_TIMERS; k++) begin : g_lane
    assign vals[k] = tmr_val_i[k*VAL_W +: VAL_W];
    assign en_d[k] = stb_i && (tag_nxt_i == TAG_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_val_o <= '0;
      slot_en_o <= '0;
    end else begin
      bus_val_o <= vals[tag_nxt_i];
      slot_en_o <= en_d;
    end
  end
endmodule

// File: rtl/tbus_seq.sv
module tbus_seq
  import tbus_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int VAL_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      st_stb_i,
  input  logic                      mode_i,
  input  logic [N_TIMERS*VAL_W-1:0] tmr_val_i,
  output logic [VAL_W-1:0]          bus_val_o,
  output logic [1:0]                bus_tag_o,
  output logic [N_TIMERS-1:0]       slot_en_o
);
  localparam int TAG_W = 2;

  logic [TAG_W-1:0] tag_nxt;
  tbus_mode_e       mode_q;

  tbus_slot_seq #(.N_TIMERS(N_TIMERS), .TAG_W(TAG_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .stb_i     (st_stb_i),
    .mode_i    (mode_i),
    .tag_o     (bus_tag_o),
    .tag_nxt_o (tag_nxt),
    .mode_o    (mode_q)
  );

  tbus_out_stage #(.N_TIMERS(N_TIMERS), .VAL_W(VAL_W), .TAG_W(TAG_W)) out_i (
    .clk       (clk),
    .rst       (rst),
    .stb_i     (st_stb_i),
    .tag_nxt_i (tag_nxt),
    .tmr_val_i (tmr_val_i),
    .bus_val_o (bus_val_o),
    .slot_en_o (slot_en_o)
  );
endmodule

// File: rtl/tbus_seq_chk.sv
module tbus_seq_chk #(
  parameter int N_TIMERS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                st_stb_i,
  input logic                mode_i,
  input logic [1:0]          bus_tag_o,
  input logic [N_TIMERS-1:0] slot_en_o,
  input logic                mode_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk) $past(rst) |-> (bus_tag_o == 2'd1 && slot_en_o == '0));
  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st_stb_i && bus_tag_o != 2'd0) |=> (bus_tag_o == $past(bus_tag_o) - 2'd1));
  // R4
  pair_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 1'b0) |-> (bus_tag_o < 2'(N_TIMERS / 2)));
  // R5
  en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    st_stb_i |=> (slot_en_o == (N_TIMERS'(1) << bus_tag_o)));
  // R5
  en_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !st_stb_i |=> (slot_en_o == '0));
  // R7
  rot_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (st_stb_i && bus_tag_o == 2'd0) |=> (bus_tag_o == ($past(mode_i) ? 2'd3 : 2'd1)));
  // R8
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !st_stb_i |=> $stable(bus_tag_o));
endmodule

bind tbus_seq tbus_seq_chk #(.N_TIMERS(N_TIMERS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .st_stb_i  (st_stb_i),
  .mode_i    (mode_i),
  .bus_tag_o (bus_tag_o),
  .slot_en_o (slot_en_o),
  .mode_q    (mode_q)
);

// File: tb/tbus_seq_tb_top.sv
`timescale 1ns/1ps
module tbus_seq_tb_top;
  localparam int NT = 4;
  localparam int VW = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             st_stb_i = 1'b0;
  logic             mode_i = 1'b0;
  logic [NT*VW-1:0] tmr_val_i = '0;
  logic [VW-1:0]    bus_val_o;
  logic [1:0]       bus_tag_o;
  logic [NT-1:0]    slot_en_o;

  int checks = 0;
  int failures = 0;

  // bench model state
  int            m_tag = 1;
  bit            m_mode = 1'b0;
  logic [VW-1:0] m_val = '0;
  logic [NT-1:0] m_en = '0;

  always #2.5 clk = ~clk;

  tbus_seq #(.N_TIMERS(NT), .VAL_W(VW)) dut_i (
    .clk(clk), .rst(rst), .st_stb_i(st_stb_i), .mode_i(mode_i),
    .tmr_val_i(tmr_val_i), .bus_val_o(bus_val_o), .bus_tag_o(bus_tag_o),
    .slot_en_o(slot_en_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // slot that follows from the requirements: countdown, reload at tag 0 with sampled mode
  function automatic int next_tag(input int tag, input bit stb, input bit md, inout bit cur_mode);
    if (!stb) return tag;
    if (tag == 0) begin
      cur_mode = md;
      return md ? 3 : 1;
    end
    return tag - 1;
  endfunction

  // drive one cycle at a falling edge, then check at the next falling edge
  task automatic step(input bit stb, input bit md, input string tag_req);
    logic [NT*VW-1:0] v;
    for (int k = 0; k < NT; k++) v[k*VW +: VW] = VW'($urandom);
    st_stb_i  = stb;
    mode_i    = md;
    tmr_val_i = v;
    m_tag = next_tag(m_tag, stb, md, m_mode);
    m_en  = stb ? (NT'(1) << m_tag) : '0;
    m_val = v[m_tag*VW +: VW];
    @(negedge clk);
    chk(bus_tag_o == 2'(m_tag), stb ? tag_req : "R8", bus_tag_o, m_tag);
    chk(slot_en_o == m_en, "R5", slot_en_o, m_en);
    chk(bus_val_o == m_val, "R6", bus_val_o, m_val);
    if (!m_mode) chk(bus_tag_o < 2'd2 && slot_en_o[3:2] == 2'b00, "R4", {slot_en_o, bus_tag_o}, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit md;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(bus_tag_o == 2'd1, "R1", bus_tag_o, 1);
    chk(slot_en_o == '0, "R1", slot_en_o, 0);
    chk(bus_val_o == '0, "R1", bus_val_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_tag_o == 2'd1 && slot_en_o == '0, "R1", {slot_en_o, bus_tag_o}, 1);
    // R2 steady two-timer rotation, strobe every other cycle
    for (int i = 0; i < 16; i++) step(i % 2 == 0, 1'b0, "R2");
    // R8 strobe gap
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R8");
    // R7 mode raised mid rotation: walk to tag 1 first
    while (m_tag != 1) step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, "R7");   // tag 1 -> 0, mode ignored
    chk(bus_tag_o == 2'd0, "R7", bus_tag_o, 0);
    step(1'b1, 1'b1, "R7");   // rotation boundary: takes four-timer
    chk(bus_tag_o == 2'd3, "R7", bus_tag_o, 3);
    // R3 four-timer rotation
    for (int i = 0; i < 12; i++) step(i % 2 == 0, 1'b1, "R3");
    // R7 drop to two-timer mid rotation
    while (m_tag != 2) step(1'b1, 1'b1, "R3");
    step(1'b1, 1'b0, "R7");
    chk(bus_tag_o == 2'd1, "R7", bus_tag_o, 1);
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    chk(bus_tag_o == 2'd1, "R7", bus_tag_o, 1);
    // random run
    md = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 32 == 0) md = ~md;
      step(($urandom % 3) != 0, md, m_tag == 0 ? "R7" : (m_mode ? "R3" : "R2"));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule